// File: doc/BRIEF.md
# Ripple-Carry Integer ALU

This block is a purely combinational integer arithmetic and logic unit of parameterized width, 32 bits by default. A chain of identical one-bit slices is built around full adders. Carries ripple from the least significant slice to the most significant one. A small decoder turns a 4-bit operation code into the controls that every slice shares: whether to invert B, which per-bit function to select, and the carry into bit 0.

Subtraction is formed as A plus the complement of B plus one. Signed and unsigned variants give the same data result and differ only in whether an overflow is reported. The set-less-than operations drive a single comparison bit into bit 0 and zeros into every other bit. That comparison bit comes from the sign of the top adder output, corrected by the signed overflow, or from the final borrow for the unsigned case.

The unit has no clock and no reset. A host pipeline registers around it as it needs, and every output follows A, B and the opcode within the same evaluation. The operands and results are plain combinational values, so there is no valid/ready handshake and no back-pressure.

Top module: `rc_alu32`

## Requirements
- R1: Opcodes 4'b0000 (add) and 4'b0001 (addu) give result = (A + B) mod 2^W.
- R2: Opcodes 4'b0010 (sub) and 4'b0011 (subu) give result = (A - B) mod 2^W.
- R3: Opcodes 4'b0100, 4'b0101, 4'b0110 and 4'b0111 give, bit for bit, A AND B, A OR B, A XOR B and NOT (A OR B).
- R4: Opcode 4'b1010 (slt) gives result bit 0 = 1 exactly when A < B as two's complement numbers, also when A - B overflows, and result bits W-1..1 = 0.
- R5: Opcode 4'b1011 (sltu) gives result bit 0 = 1 exactly when A < B as unsigned numbers, and result bits W-1..1 = 0.
- R6: The opcodes 4'b1000, 4'b1001 and 4'b1100 through 4'b1111 give a result of all zeros.
- R7: carry_out is the carry out of the top bit position of the adder. For sub, subu, slt and sltu the adder computes A + ~B + 1. For every other opcode it computes A + B.
- R8: For addu, subu and sltu, overflow is 0. For every other opcode, overflow is 1 exactly when that adder operation overflows as a signed number, which is the carry into the top bit XOR the carry out of it.
- R9: zero is 1 exactly when every bit of the selected result is 0, and not when only the adder sum is 0.
- R10: All outputs settle in the same evaluation as a change of A, B or the opcode, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op | input | 4 | Operation code |
| result | output | 32 | Selected result |
| carry_out | output | 1 | Carry out of the most significant adder position |
| overflow | output | 1 | Signed overflow of the adder operation, forced 0 for unsigned opcodes |
| zero | output | 1 | High when result is all zeros |

## Verification
The unit holds no state, so any internal fault shows at the ports in the same evaluation as the input that exposes it. A broken link in the carry chain corrupts the result of add or subtract from that bit upward, and it also corrupts carry_out. A wrong inversion or a wrong carry-in decode shifts every difference by one or turns it into a sum. The set-less-than path is exposed only by operand pairs whose difference overflows or whose operands straddle the sign bit, so the stimulus includes those pairs on purpose next to random operands for all sixteen opcodes.

// File: rtl/rc_alu_pkg.sv
package rc_alu_pkg;

  typedef enum logic [3:0] {
    OPC_ADD  = 4'b0000,
    OPC_ADDU = 4'b0001,
    OPC_SUB  = 4'b0010,
    OPC_SUBU = 4'b0011,
    OPC_AND  = 4'b0100,
    OPC_OR   = 4'b0101,
    OPC_XOR  = 4'b0110,
    OPC_NOR  = 4'b0111,
    OPC_SLT  = 4'b1010,
    OPC_SLTU = 4'b1011
  } opc_e;

  typedef enum logic [2:0] {
    PICK_SUM  = 3'd0,
    PICK_AND  = 3'd1,
    PICK_OR   = 3'd2,
    PICK_XOR  = 3'd3,
    PICK_NOR  = 3'd4,
    PICK_LESS = 3'd5,
    PICK_NONE = 3'd6
  } pick_e;

  typedef struct packed {
    logic  flip_b;
    logic  carry_seed;
    logic  ovf_en;
    logic  cmp_unsigned;
    pick_e pick;
  } slice_ctl_t;

endpackage

// File: rtl/rc_alu_decode.sv
module rc_alu_decode
  import rc_alu_pkg::*;
(
  input  logic [3:0]  op,
  output slice_ctl_t  ctl
);

  always_comb begin
    ctl.flip_b       = 1'b0;
    ctl.carry_seed   = 1'b0;
    ctl.ovf_en       = 1'b1;
    ctl.cmp_unsigned = 1'b0;
    ctl.pick         = PICK_NONE;
    case (op)
      OPC_ADD:  ctl.pick = PICK_SUM;
      OPC_ADDU: begin
        ctl.pick   = PICK_SUM;
        ctl.ovf_en = 1'b0;
      end
      OPC_SUB: begin
        ctl.pick       = PICK_SUM;
        ctl.flip_b     = 1'b1;
        ctl.carry_seed = 1'b1;
      end
      OPC_SUBU: begin
        ctl.pick       = PICK_SUM;
        ctl.flip_b     = 1'b1;
        ctl.carry_seed = 1'b1;
        ctl.ovf_en     = 1'b0;
      end
      OPC_AND:  ctl.pick = PICK_AND;
      OPC_OR:   ctl.pick = PICK_OR;
      OPC_XOR:  ctl.pick = PICK_XOR;
      OPC_NOR:  ctl.pick = PICK_NOR;
      OPC_SLT: begin
        ctl.pick       = PICK_LESS;
        ctl.flip_b     = 1'b1;
        ctl.carry_seed = 1'b1;
      end
      OPC_SLTU: begin
        ctl.pick         = PICK_LESS;
        ctl.flip_b       = 1'b1;
        ctl.carry_seed   = 1'b1;
        ctl.ovf_en       = 1'b0;
        ctl.cmp_unsigned = 1'b1;
      end
      default: ctl.pick = PICK_NONE;
    endcase
  end

endmodule

// File: rtl/rc_alu_slice.sv
module rc_alu_slice
  import rc_alu_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  logic       c_in,
  input  logic       less_in,
  input  slice_ctl_t ctl,
  output logic       sum_bit,
  output logic       c_out,
  output logic       y_bit
);

  logic b_eff;
  logic half;

  assign b_eff   = b_bit ^ ctl.flip_b;
  assign half    = a_bit ^ b_eff;
  assign sum_bit = half ^ c_in;
  assign c_out   = (a_bit & b_eff) | (half & c_in);

  always_comb begin
    case (ctl.pick)
      PICK_SUM:  y_bit = sum_bit;
      PICK_AND:  y_bit = a_bit & b_bit;
      PICK_OR:   y_bit = a_bit | b_bit;
      PICK_XOR:  y_bit = a_bit ^ b_bit;
      PICK_NOR:  y_bit = ~(a_bit | b_bit);
      PICK_LESS: y_bit = less_in;
      default:   y_bit = 1'b0;
    endcase
  end

endmodule

// File: rtl/rc_alu_zero_tree.sv
module rc_alu_zero_tree #(
  parameter int W = 32
) (
  input  logic [W-1:0] v,
  output logic         all_zero
);

  localparam int LVL = (W > 1) ? $clog2(W) : 1;
  localparam int P   = 1 << LVL;

  logic [2*P-1:1] node;

  genvar i;
  generate
    for (i = 0; i < P; i++) begin : g_leaf
      if (i < W) begin : g_real
        assign node[P+i] = ~v[i];
      end else begin : g_pad
        assign node[P+i] = 1'b1;
      end
    end
    for (i = 1; i < P; i++) begin : g_join
      assign node[i] = node[2*i] & node[2*i+1];
    end
  endgenerate

  assign all_zero = node[1];

endmodule

// File: rtl/rc_alu32.sv
module rc_alu32
  import rc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         overflow,
  output logic         zero
);

  localparam int MSB = W - 1;

  slice_ctl_t   ctl;
  logic [W:0]   chain;
  logic [W-1:0] sums;
  logic         ovf_raw;
  logic         cmp_bit;

  rc_alu_decode u_decode (
    .op  (op),
    .ctl (ctl)
  );

  assign chain[0] = ctl.carry_seed;

  genvar k;
  generate
    for (k = 0; k < W; k++) begin : g_slice
      if (k == 0) begin : g_lsb
        rc_alu_slice u_slice (
          .a_bit   (a[k]),
          .b_bit   (b[k]),
          .c_in    (chain[k]),
          .less_in (cmp_bit),
          .ctl     (ctl),
          .sum_bit (sums[k]),
          .c_out   (chain[k+1]),
          .y_bit   (result[k])
        );
      end else begin : g_upper
        rc_alu_slice u_slice (
          .a_bit   (a[k]),
          .b_bit   (b[k]),
          .c_in    (chain[k]),
          .less_in (1'b0),
          .ctl     (ctl),
          .sum_bit (sums[k]),
          .c_out   (chain[k+1]),
          .y_bit   (result[k])
        );
      end
    end
  endgenerate

  assign ovf_raw   = chain[MSB] ^ chain[W];
  assign cmp_bit   = ctl.cmp_unsigned ? ~chain[W] : (sums[MSB] ^ ovf_raw);
  assign carry_out = chain[W];
  assign overflow  = ctl.ovf_en & ovf_raw;

  rc_alu_zero_tree #(.W(W)) u_zero (
    .v        (result),
    .all_zero (zero)
  );

endmodule

// File: rtl/rc_alu32_chk.sv
module rc_alu32_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [3:0]   op,
  input logic [W-1:0] result,
  input logic         overflow,
  input logic         zero
);

  always_comb begin
    if (op == 4'b0000 || op == 4'b0001)
      AST_ADD_SUM: assert (result == W'(a + b)); // R1
    if (op == 4'b0010 || op == 4'b0011)
      AST_SUB_DIFF: assert (result == W'(a - b)); // R2
    if (op == 4'b1010 || op == 4'b1011)
      AST_CMP_UPPER_CLEAR: assert (result[W-1:1] == '0); // R4
    if (op == 4'b1011)
      AST_SLTU_ORDER: assert (result[0] == (a < b)); // R5
    if (op == 4'b1000 || op == 4'b1001 || op[3:2] == 2'b11)
      AST_BAD_OP_CLEAR: assert (result == '0); // R6
    if (op == 4'b0001 || op == 4'b0011 || op == 4'b1011)
      AST_NO_OVERFLOW: assert (!overflow); // R8
    if (zero)
      AST_ZERO_MEANS_CLEAR: assert (result == '0); // R9
    if (result == '0)
      AST_CLEAR_MEANS_ZERO: assert (zero); // R9
  end

endmodule

bind rc_alu32 rc_alu32_chk #(.W(W)) u_chk (
  .a        (a),
  .b        (b),
  .op       (op),
  .result   (result),
  .overflow (overflow),
  .zero     (zero)
);

// File: tb/rc_alu32_tb.sv
module rc_alu32_tb;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [3:0]   op = 4'b0000;
  logic [W-1:0] result;
  logic         carry_out;
  logic         overflow;
  logic         zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rc_alu32 #(.W(W)) u_dut (
    .a         (a),
    .b         (b),
    .op        (op),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow),
    .zero      (zero)
  );

  // {a, b, op, expected result}
  localparam int NV = 14;
  localparam logic [99:0] VEC [NV] = '{
    {32'h0000_0005, 32'h0000_0003, 4'b0000, 32'h0000_0008},
    {32'hFFFF_FFFF, 32'h0000_0001, 4'b0001, 32'h0000_0000},
    {32'h0000_000A, 32'h0000_0003, 4'b0010, 32'h0000_0007},
    {32'h0000_0000, 32'h0000_0001, 4'b0011, 32'hFFFF_FFFF},
    {32'hF0F0_F0F0, 32'hFF00_FF00, 4'b0100, 32'hF000_F000},
    {32'hF0F0_F0F0, 32'hFF00_FF00, 4'b0101, 32'hFFF0_FFF0},
    {32'hF0F0_F0F0, 32'hFF00_FF00, 4'b0110, 32'h0FF0_0FF0},
    {32'hF0F0_F0F0, 32'hFF00_FF00, 4'b0111, 32'h000F_000F},
    {32'h8000_0000, 32'h0000_0001, 4'b1010, 32'h0000_0001},
    {32'h8000_0000, 32'h0000_0001, 4'b1011, 32'h0000_0000},
    {32'h7FFF_FFFF, 32'h8000_0000, 4'b1010, 32'h0000_0000},
    {32'h8000_0000, 32'h7FFF_FFFF, 4'b1010, 32'h0000_0001},
    {32'h1234_5678, 32'h1234_5678, 4'b1100, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1001, 32'h0000_0000}
  };

  function automatic logic [W+2:0] model(input logic [W-1:0] x,
                                         input logic [W-1:0] y,
                                         input logic [3:0] o);
    logic [W:0]   s;
    logic [W-1:0] r;
    logic         sub_like, ov;
    sub_like = (o == 4'b0010) || (o == 4'b0011) || (o == 4'b1010) || (o == 4'b1011);
    if (sub_like) begin
      s  = {1'b0, x} + {1'b0, ~y} + 1;
      ov = (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
    end else begin
      s  = {1'b0, x} + {1'b0, y};
      ov = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
    end
    case (o)
      4'b0000, 4'b0001, 4'b0010, 4'b0011: r = s[W-1:0];
      4'b0100: r = x & y;
      4'b0101: r = x | y;
      4'b0110: r = x ^ y;
      4'b0111: r = ~(x | y);
      4'b1010: r = W'($signed(x) < $signed(y));
      4'b1011: r = W'(x < y);
      default: r = '0;
    endcase
    if (o == 4'b0001 || o == 4'b0011 || o == 4'b1011) ov = 1'b0;
    return {r, s[W], ov, (r == '0)};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [3:0] o);
    @(posedge clk);
    a  = x;
    b  = y;
    op = o;
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    logic [W+2:0] e;
    e = model(a, b, op);
    check(req, "result", result, e[W+2:3]);
    check(req, "carry_out", W'(carry_out), W'(e[2]));
    check(req, "overflow", W'(overflow), W'(e[1]));
    check(req, "zero", W'(zero), W'(e[0]));
  endtask

  function automatic string tag_for(input logic [3:0] o);
    case (o)
      4'b0000, 4'b0001: return "R1";
      4'b0010, 4'b0011: return "R2";
      4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R3";
      4'b1010: return "R4";
      4'b1011: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    // watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle state: zero operands with add
    check("R9", "idle result", result, '0);
    check("R9", "idle zero", W'(zero), W'(1));
    check("R7", "idle carry", W'(carry_out), '0);
    check("R8", "idle overflow", W'(overflow), '0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][99:68], VEC[i][67:36], VEC[i][35:32]);
      check(tag_for(op), "table result", result, VEC[i][31:0]);
      check_all(tag_for(op));
    end

    // R7 carry out of subtract with no borrow, R8 signed add overflow
    apply(32'h0000_0005, 32'h0000_0003, 4'b0010);
    check("R7", "sub carry", W'(carry_out), W'(1));
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0000);
    check("R8", "add overflow", W'(overflow), W'(1));
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'b0001);
    check("R8", "addu overflow masked", W'(overflow), '0);
    apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0100);
    check("R7", "and carry", W'(carry_out), W'(1));
    // R9: sum zero but selected result not zero
    apply(32'hFFFF_FFFF, 32'h0000_0001, 4'b0101);
    check("R9", "or zero flag", W'(zero), '0);
    // R9: sum non-zero but selected result zero
    apply(32'h0000_0001, 32'h0000_0002, 4'b0100);
    check("R9", "and zero flag", W'(zero), W'(1));

    // R10: change inputs between edges, outputs follow at once
    @(negedge clk);
    a = 32'h0000_0010; b = 32'h0000_0001; op = 4'b0011;
    #1;
    check("R10", "same-evaluation diff", result, 32'h0000_000F);
    op = 4'b0000;
    #1;
    check("R10", "same-evaluation sum", result, 32'h0000_0011);

    // random sweep over every opcode
    seed = 32'h1357_9BDF;
    for (int n = 0; n < 4000; n++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (n % 5 == 0) rb = ra;
      if (n % 7 == 0) ra = {ra[W-1], {(W-1){~ra[W-1]}}};
      apply(ra, rb, 4'(n));
      check_all(tag_for(op));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule